// File: doc/BRIEF.md
# Handshaked Address Classifier

This block sorts a 16-bit address into one of three classes after a four-phase request: the all-ones address (FFFF), the address one below it (FFFE), and every other value. The answer comes back as three result lines, exactly one of which rises per request, so the result doubles as the acknowledge of the handshake. A requester raises the request with the address applied, waits for a result line, lowers the request, and waits for every result line to fall before it may start again.

Internally each address bit is turned into a dual-rail pair (a true rail and a false rail) that is latched on the first clock edge that sees the request high. A completion detector watches the per-bit acknowledges and marks the word valid only once all of them are set. One shared test checks whether bits 15 down to 1 are all ones (and its complement, whether any of them is zero); bit 0's rails then split the all-ones case into the two top addresses. Result lines rise only while completion is high and fall only after completion, the compare outputs and the bit-0 rail they used have all returned low. The analog precharge of a self-timed comparator is modelled as clocked logic, one register stage per step.

Top module: `addr_class_hs`

## Requirements
- R1: While reset is asserted and on the first clock after it, all three result lines (`is_top_o`, `is_next_o`, `is_other_o`) are low.
- R2: For address FFFF, `is_top_o` is the only result line that rises.
- R3: For address FFFE, `is_next_o` is the only result line that rises.
- R4: For any address with at least one zero among bits 15..1, `is_other_o` is the only result line that rises.
- R5: At no time is more than one result line high; the result vector {is_other_o, is_next_o, is_top_o} is one-hot for every request.
- R6: If the first rising edge that samples `req_i` high is edge n, the result line is high after edge n+2 and all result lines are still low after edge n+1.
- R7: The address is captured on edge n; changes to `addr_i` after that edge while the request stays high do not change the result.
- R8: If the first edge that samples `req_i` low is edge m, the result line is still high after edge m+1 and all result lines are low after edge m+2; a new request may be raised only while all result lines are low.
- R9: While `req_i` stays high, the asserted result line stays high.
- R10: A result line rises only after the completion of all 16 dual-rail bits has been detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Four-phase request |
| addr_i | input | 16 | Address to classify |
| is_top_o | output | 1 | Address was FFFF |
| is_next_o | output | 1 | Address was FFFE |
| is_other_o | output | 1 | Address had a zero among bits 15..1 |

## Verification
The capture of the address into the dual-rail latches and a change of the address on the bus can fall into the same request: the completion stage forms while the requester is already free to move the address. The bench provokes this by switching the address to a value of a different class right after the capture edge and judges it by demanding the class of the original address with the R6 timing. The release of a result and the raising of a fresh request are the other pair that meet; the bench always raises the next request on the cycle right after the last result line falls and checks the new answer on its own latency.

// File: rtl/hsac_pkg.sv
package hsac_pkg;
    localparam int unsigned ADDR_W = 16;

    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef struct packed {
        logic top;
        logic next;
        logic other;
    } result_t;
endpackage

// File: rtl/hsac_rail_conv.sv
module hsac_rail_conv #(
    parameter int unsigned W = hsac_pkg::ADDR_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         req_i,
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] rail_t_o,
    output logic [W-1:0] rail_f_o,
    output logic [W-1:0] ack_o
);
    import hsac_pkg::*;

    for (genvar k = 0; k < W; k++) begin : g_bit
        rail_t bit_d, bit_q;

        always_comb begin
            bit_d = bit_q;
            if (!req_i) begin
                bit_d = '0;
            end else if (!(bit_q.t || bit_q.f)) begin
                bit_d.t = addr_i[k];
                bit_d.f = ~addr_i[k];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) bit_q <= '0;
            else         bit_q <= bit_d;
        end

        assign rail_t_o[k] = bit_q.t;
        assign rail_f_o[k] = bit_q.f;
        assign ack_o[k]    = bit_q.t | bit_q.f;

        // R7: once a bit is acknowledged it holds for the rest of the request
        assert_rail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i && $past(req_i) && $past(ack_o[k])) |-> $stable(rail_t_o[k]));
    end
endmodule

// File: rtl/hsac_done_detect.sv
module hsac_done_detect #(
    parameter int unsigned W = hsac_pkg::ADDR_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] ack_i,
    output logic         done_o
);
    logic all_set, none_set;
    logic done_d, done_q;

    assign all_set  = &ack_i;
    assign none_set = ~|ack_i;

    always_comb begin
        done_d = done_q;
        if (all_set)       done_d = 1'b1;
        else if (none_set) done_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) done_q <= 1'b0;
        else         done_q <= done_d;
    end

    assign done_o = done_q;

    // R10: completion only rises after every bit acknowledged
    assert_done_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(all_set));
endmodule

// File: rtl/hsac_match.sv
module hsac_match #(
    parameter int unsigned W = hsac_pkg::ADDR_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         req_i,
    input  logic [W-1:0] rail_t_i,
    input  logic [W-1:0] rail_f_i,
    output logic         all_hi_o,
    output logic         some_lo_o
);
    typedef struct packed {
        logic all_hi;
        logic some_lo;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d.all_hi  = req_i & (&rail_t_i[W-1:1]);
        cmp_d.some_lo = req_i & (|rail_f_i[W-1:1]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_q <= '0;
        else         cmp_q <= cmp_d;
    end

    assign all_hi_o  = cmp_q.all_hi;
    assign some_lo_o = cmp_q.some_lo;

    // R5: the shared test never reports both outcomes
    assert_cmp_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(all_hi_o && some_lo_o));
endmodule

// File: rtl/addr_class_hs.sv
module addr_class_hs #(
    parameter int unsigned ADDR_W = hsac_pkg::ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_top_o,
    output logic              is_next_o,
    output logic              is_other_o
);
    import hsac_pkg::*;

    logic [ADDR_W-1:0] rail_t, rail_f, ack;
    logic              done, all_hi, some_lo;
    result_t           res_d, res_q;

    hsac_rail_conv #(.W(ADDR_W)) rail_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .addr_i   (addr_i),
        .rail_t_o (rail_t),
        .rail_f_o (rail_f),
        .ack_o    (ack)
    );

    hsac_done_detect #(.W(ADDR_W)) done_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ack_i  (ack),
        .done_o (done)
    );

    hsac_match #(.W(ADDR_W)) match_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .rail_t_i  (rail_t),
        .rail_f_i  (rail_f),
        .all_hi_o  (all_hi),
        .some_lo_o (some_lo)
    );

    // Each result behaves as a C-element: set when all its inputs are high,
    // cleared only when all of them have returned low.
    always_comb begin
        res_d = res_q;
        if (done && all_hi && rail_t[0])          res_d.top = 1'b1;
        else if (!done && !all_hi && !rail_t[0])  res_d.top = 1'b0;
        if (done && all_hi && rail_f[0])          res_d.next = 1'b1;
        else if (!done && !all_hi && !rail_f[0])  res_d.next = 1'b0;
        if (done && some_lo)                      res_d.other = 1'b1;
        else if (!done && !some_lo)               res_d.other = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign is_top_o   = res_q.top;
    assign is_next_o  = res_q.next;
    assign is_other_o = res_q.other;

    assert_res_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({is_other_o, is_next_o, is_top_o}));

    assert_res_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(is_top_o || is_next_o || is_other_o) |-> done);

    assert_req_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i) |-> !(is_top_o || is_next_o || is_other_o));

    assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && $past(req_i) && $past(is_top_o || is_next_o || is_other_o))
        |-> $stable({is_other_o, is_next_o, is_top_o}));
endmodule

// File: tb/addr_class_hs_tb_top.sv
`timescale 1ns/1ps
module addr_class_hs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic        top, nxt, other;
    int          checks = 0;
    int          failures = 0;

    always #2.5 clk = ~clk;

    addr_class_hs dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .is_top_o   (top),
        .is_next_o  (nxt),
        .is_other_o (other)
    );

    // {expected {other,next,top}, address}
    localparam logic [18:0] VEC [12] = '{
        {3'b001, 16'hFFFF}, {3'b010, 16'hFFFE}, {3'b100, 16'h0000},
        {3'b100, 16'h0001}, {3'b100, 16'h7FFF}, {3'b100, 16'hFFFD},
        {3'b100, 16'hFFFC}, {3'b100, 16'hBFFF}, {3'b100, 16'hAAAA},
        {3'b100, 16'h5555}, {3'b100, 16'hFEFF}, {3'b100, 16'h8001}
    };

    function automatic logic [2:0] model(input logic [15:0] a);
        if (a == 16'hFFFF)      return 3'b001;
        else if (a == 16'hFFFE) return 3'b010;
        else                    return 3'b100;
    endfunction

    task automatic chk(input string req_tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b addr=%h", req_tag, act, exp, addr);
        end
    endtask

    // One full handshake; optionally moves the address after the capture edge.
    task automatic run_tx(input logic [15:0] a, input logic [2:0] exp,
                          input bit swap, input logic [15:0] other_a, input int hold);
        @(negedge clk);
        chk("R8 idle before request", {other, nxt, top}, 3'b000);
        addr = a;
        req  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (swap) addr = other_a;
        @(posedge clk);
        @(negedge clk);
        chk("R6 low after second edge", {other, nxt, top}, 3'b000);
        @(posedge clk);
        @(negedge clk);
        chk(swap ? "R7 captured address" : "R2/R3/R4 class", {other, nxt, top}, exp);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R9 held while request high", {other, nxt, top}, exp);
        end
        req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 still high after m+1", {other, nxt, top}, exp);
        @(posedge clk);
        @(negedge clk);
        chk("R8 low after m+2", {other, nxt, top}, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        addr = 16'hFFFF;
        req  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", {other, nxt, top}, 3'b000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 first clock after reset", {other, nxt, top}, 3'b000);

        for (int v = 0; v < 12; v++)
            run_tx(VEC[v][15:0], VEC[v][18:16], 1'b0, 16'h0, 0);

        // R2 R3 R4 R5: single zero in every bit position
        for (int b = 0; b < 16; b++)
            run_tx(~(16'h1 << b), model(~(16'h1 << b)), 1'b0, 16'h0, 0);

        // R5: stride sweep plus the top page exhaustively
        for (int a = 0; a < 65536; a += 97)
            run_tx(a[15:0], model(a[15:0]), 1'b0, 16'h0, 0);
        for (int a = 16'hFF00; a < 65536; a++)
            run_tx(a[15:0], model(a[15:0]), 1'b0, 16'h0, 0);

        // R7: address moved to another class after capture
        run_tx(16'hFFFF, 3'b001, 1'b1, 16'h0000, 0);
        run_tx(16'hFFFE, 3'b010, 1'b1, 16'hFFFF, 0);
        run_tx(16'h1234, 3'b100, 1'b1, 16'hFFFE, 0);

        // R9: long hold of the request
        run_tx(16'hFFFE, 3'b010, 1'b0, 16'h0, 20);
        run_tx(16'h0F0F, 3'b100, 1'b0, 16'h0, 7);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule